// File: doc/BRIEF.md
# Multi-space indexed register bridge

The bridge gives a host six internal register spaces through a single pair of 32-bit I/O ports. The host writes an index word to the index port, then reads or writes the data port, which always sits four bytes above the index port. The top three bits of the index word pick a space. The lower bits pick a register in that space. One space is split into per-port banks by a port field. Two spaces are reached one level deeper: the index word points at an inner index register or an inner data window, and the inner data window reaches the register that the inner index names.

The index port does not sit at a fixed address. A relocation register holds its base address. That register is reached through a separate small index/data pair at a fixed address, at inner offset 0xE0. Every space is modelled as an array of DEPTH 32-bit words. All storage clears on reset.

Top module: `ixbridge`

## Requirements
- R1: After reset every register in every space reads 0, the index register reads 0, both inner index registers read 0, and the relocation register reads BASE_RST (default 0x0CD8).
- R2: The fixed pair sits at FIX_ADDR (selector) and FIX_ADDR+1 (data), default 0x0CD6/0x0CD7. With selector 0xE0, the data port reads and writes the relocation register, and address bits 1:0 are forced to 0 on write. With any other selector value, the data port reads 0xFFFFFFFF and writes to it change nothing.
- R3: The index port answers at the relocation address and the data port at that address plus 4. Reads of any other non-fixed address return 0xFFFFFFFF. After a relocation, the old addresses no longer respond.
- R4: Index codes 110, 100 and 001 in bits 31:29 select three independent direct spaces. Bits 7:0 of the index word are the register number, used directly by the next data-port access.
- R5: Index code 011 selects a per-port space. Bits 28:24 give the port number (0..NPORTS-1), and each port has its own registers.
- R6: Index codes 000 and 010 select two nested spaces, each with its own inner index register at register number 0x30 and inner data window at 0x34. The window accesses entry (inner index) of that space.
- R7: Unimplemented codes (101, 111), register numbers at or above DEPTH, port numbers at or above NPORTS, inner index values at or above DEPTH, and other register numbers in the nested codes all read 0xFFFFFFFF. Writes to them change no register.
- R8: On every write, only the bytes whose io_be bit is set are updated. Bit 0 covers bits 7:0 and bit 3 covers bits 31:24.
- R9: The index register keeps its value until the index port is written again, so repeated data-port accesses reach the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Access strobe, one access per cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | I/O port address |
| io_be | input | 4 | Byte enables for writes |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |

## Verification
The hardest case to reach is a nested-space access after the index port has been moved. It needs the fixed pair, a new base, a write to the index at the new address, an inner index write through the window, and finally the data access. A correct value comes back only if all four layers of decode agree. The bench drives this whole chain in one task. It then reads the old base address to confirm that it no longer answers. It also writes to out-of-range register numbers and reads the entries that a truncated address would alias onto, which shows that the write was dropped rather than wrapped.

// File: rtl/ixbridge.sv
module ixbridge #(
  parameter int          ADDR_W   = 16,
  parameter int          DEPTH    = 64,
  parameter int          NPORTS   = 2,
  parameter logic [15:0] FIX_ADDR = 16'h0CD6,
  parameter logic [15:0] BASE_RST = 16'h0CD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [3:0]        io_be,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata
);
  localparam int TOTAL = (5 + NPORTS) * DEPTH;
  localparam int MW    = $clog2(TOTAL);
  localparam logic [31:0] ONES = '1;

  logic [31:0]       mem [TOTAL];
  logic [31:0]       idx, sidx;
  logic [31:0]       ii [2];
  logic [ADDR_W-1:0] base;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    for (int b = 0; b < 4; b++)
      merge[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
  endfunction

  wire at_fidx = io_addr == ADDR_W'(FIX_ADDR);
  wire at_fdat = io_addr == ADDR_W'(FIX_ADDR) + ADDR_W'(1);
  wire at_idx  = !at_fidx && !at_fdat && io_addr == base;
  wire at_dat  = !at_fidx && !at_fdat && io_addr == base + ADDR_W'(4);
  wire wr      = io_valid && io_write;

  wire [7:0] off    = idx[7:0];
  wire [4:0] port   = idx[28:24];
  wire       off_ok = 32'(off) < 32'(DEPTH);

  logic          mem_hit, ii_hit, ii_n;
  logic [MW-1:0] mem_a;

  always_comb begin
    mem_hit = 1'b0;
    ii_hit  = 1'b0;
    ii_n    = idx[30];
    mem_a   = '0;
    case (idx[31:29])
      3'b110: begin mem_hit = off_ok; mem_a = MW'(int'(off)); end
      3'b100: begin mem_hit = off_ok; mem_a = MW'(DEPTH + int'(off)); end
      3'b001: begin mem_hit = off_ok; mem_a = MW'(2 * DEPTH + int'(off)); end
      3'b011: begin
        mem_hit = off_ok && 32'(port) < 32'(NPORTS);
        mem_a   = MW'((5 + int'(port)) * DEPTH + int'(off));
      end
      3'b000, 3'b010: begin
        ii_hit = off == 8'h30;
        if (off == 8'h34) begin
          mem_hit = ii[ii_n] < 32'(DEPTH);
          mem_a   = MW'((3 + int'(ii_n)) * DEPTH + int'(ii[ii_n][7:0]));
        end
      end
      default: ;
    endcase
  end

  wire [31:0] base_m = merge(32'(base), io_wdata, io_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
      idx   <= '0;
      sidx  <= '0;
      ii[0] <= '0;
      ii[1] <= '0;
      base  <= ADDR_W'(BASE_RST);
    end else if (wr) begin
      if (at_fidx)
        sidx <= merge(sidx, io_wdata, io_be);
      else if (at_fdat) begin
        if (sidx == 32'hE0) base <= ADDR_W'(base_m) & ~ADDR_W'(3);
      end else if (at_idx)
        idx <= merge(idx, io_wdata, io_be);
      else if (at_dat) begin
        if (mem_hit)     mem[mem_a] <= merge(mem[mem_a], io_wdata, io_be);
        else if (ii_hit) ii[ii_n]   <= merge(ii[ii_n], io_wdata, io_be);
      end
    end
  end

  always_comb begin
    io_rdata = ONES;
    if (at_fidx)                        io_rdata = sidx;
    else if (at_fdat && sidx == 32'hE0) io_rdata = 32'(base);
    else if (at_idx)                    io_rdata = idx;
    else if (at_dat && mem_hit)         io_rdata = mem[mem_a];
    else if (at_dat && ii_hit)          io_rdata = ii[ii_n];
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && at_idx) |=> $stable(idx)) else $error("index changed without write"); // R9
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && at_fdat && sidx == 32'hE0) |=> $stable(base)) else $error("base moved"); // R2
  AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && !at_fidx && !at_fdat && !at_idx && !at_dat) |-> io_rdata == ONES)
    else $error("unmapped read not all ones"); // R3
  AST_UNIMPL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && at_dat && idx[31:30] == 2'b11 && idx[29]) |-> io_rdata == ONES)
    else $error("unimplemented space read"); // R7
  AST_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && io_be == 4'h0) |=> ($stable(idx) && $stable(sidx) && $stable(base)))
    else $error("write with no byte enables changed state"); // R8
endmodule

// File: tb/ixbridge_tb_top.sv
module ixbridge_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        io_valid = 0, io_write = 0;
  logic [15:0] io_addr = 0;
  logic [3:0]  io_be = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  int          nrun = 0, nfail = 0;
  logic [15:0] cb = 16'h0CD8;

  ixbridge dut_i (.clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
                  .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nrun++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    io_valid = 1; io_write = 1; io_addr = a; io_wdata = d; io_be = be;
    @(negedge clk);
    io_valid = 0; io_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    io_valid = 1; io_write = 0; io_addr = a;
    #1 d = io_rdata;
    @(negedge clk);
    io_valid = 0;
  endtask

  task automatic acc_w(input logic [31:0] ix, input logic [31:0] d, input logic [3:0] be = 4'hF);
    wr(cb, ix); wr(cb + 16'd4, d, be);
  endtask

  task automatic acc_r(input logic [31:0] ix, output logic [31:0] d);
    wr(cb, ix); rd(cb + 16'd4, d);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    cb = 16'h0CD8;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    wr(16'h0CD6, 32'hE0); rd(16'h0CD7, d); chk("R1 reloc reset", d, 32'h0CD8);
    rd(cb, d);            chk("R1 index reset", d, 0);
    acc_r(32'hC000_0004, d); chk("R1 space reset", d, 0);
    acc_r(32'h0000_0030, d); chk("R1 inner index reset", d, 0);
  endtask

  task automatic t_direct;
    logic [31:0] d;
    acc_w(32'hC000_0004, 32'hFFFF_FFFF);
    acc_w(32'h8000_0004, 32'h1234_5678);
    acc_w(32'h2000_0004, 32'hCAFE_0001);
    acc_r(32'hC000_0004, d); chk("R4 bridge cfg", d, 32'hFFFF_FFFF);
    acc_r(32'h8000_0004, d); chk("R4 link cfg", d, 32'h1234_5678);
    acc_r(32'h2000_0004, d); chk("R4 rc core", d, 32'hCAFE_0001);
    acc_w(32'hC000_003F, 32'h0000_0A3F);
    acc_r(32'hC000_003F, d); chk("R4 last entry", d, 32'h0000_0A3F);
  endtask

  task automatic t_port;
    logic [31:0] d;
    acc_w(32'h6100_0010, 32'hB0B0_0001);
    acc_w(32'h6000_0010, 32'hA0A0_0000);
    acc_r(32'h6100_0010, d); chk("R5 port 1", d, 32'hB0B0_0001);
    acc_r(32'h6000_0010, d); chk("R5 port 0", d, 32'hA0A0_0000);
  endtask

  task automatic t_nested;
    logic [31:0] d;
    acc_w(32'h0000_0030, 32'h20);
    acc_w(32'h0000_0034, 32'h1111_2020);
    acc_w(32'h4000_0030, 32'h20);
    acc_w(32'h4000_0034, 32'h2222_4040);
    acc_r(32'h0000_0034, d); chk("R6 core window", d, 32'h1111_2020);
    acc_r(32'h4000_0034, d); chk("R6 port window", d, 32'h2222_4040);
    acc_w(32'h0000_0030, 32'h21);
    acc_r(32'h0000_0034, d); chk("R6 moved inner index", d, 0);
    acc_r(32'h4000_0030, d); chk("R6 inner index read", d, 32'h20);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    acc_r(32'hE000_0004, d); chk("R7 code 111", d, 32'hFFFF_FFFF);
    acc_r(32'hA000_0004, d); chk("R7 code 101", d, 32'hFFFF_FFFF);
    acc_w(32'hC000_0040, 32'hDEAD_BEEF);
    acc_r(32'hC000_0040, d); chk("R7 offset beyond depth", d, 32'hFFFF_FFFF);
    acc_r(32'hC000_0000, d); chk("R7 no alias to entry 0", d, 0);
    acc_r(32'h8000_0000, d); chk("R7 no spill into next space", d, 0);
    acc_w(32'h6500_0010, 32'hDEAD_BEEF);
    acc_r(32'h6500_0010, d); chk("R7 port beyond range", d, 32'hFFFF_FFFF);
    acc_w(32'h0000_0030, 32'h40);
    acc_w(32'h0000_0034, 32'hDEAD_BEEF);
    acc_r(32'h0000_0034, d); chk("R7 inner index beyond depth", d, 32'hFFFF_FFFF);
    acc_w(32'h0000_0030, 32'h0);
    acc_r(32'h0000_0034, d); chk("R7 inner write dropped", d, 0);
    acc_r(32'h0000_0010, d); chk("R7 nested other offset", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    acc_w(32'h8000_0008, 32'h1122_3344);
    wr(cb + 16'd4, 32'hAABB_CCDD, 4'b0101);
    rd(cb + 16'd4, d); chk("R8 byte enables", d, 32'h11BB_33DD);
    wr(cb + 16'd4, 32'h0, 4'b0000);
    rd(cb + 16'd4, d); chk("R8 no enables", d, 32'h11BB_33DD);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    acc_w(32'h2000_0009, 32'h0000_0001);
    wr(cb + 16'd4, 32'h0000_0002);
    rd(cb + 16'd4, d); chk("R9 repeated data write", d, 32'h0000_0002);
    rd(cb, d);         chk("R9 index held", d, 32'h2000_0009);
  endtask

  task automatic t_reloc;
    logic [31:0] d;
    wr(16'h0CD6, 32'h10);
    wr(16'h0CD7, 32'h0000_0E00);
    rd(16'h0CD7, d); chk("R2 other selector reads ones", d, 32'hFFFF_FFFF);
    wr(16'h0CD6, 32'hE0);
    rd(16'h0CD7, d); chk("R2 base unchanged", d, 32'h0CD8);
    wr(16'h0CD7, 32'h0000_0D02);
    rd(16'h0CD7, d); chk("R2 base aligned", d, 32'h0D00);
    rd(16'h0CD8, d); chk("R3 old base silent", d, 32'hFFFF_FFFF);
    rd(16'h0D00, d); chk("R3 index kept at new base", d, 32'h2000_0009);
    cb = 16'h0D00;
    rd(16'h0D04, d); chk("R3 data at base+4", d, 32'h0000_0002);
    acc_w(32'h0000_0030, 32'h20);
    acc_r(32'h0000_0034, d); chk("R6 nested after relocation", d, 32'h1111_2020);
    rd(16'h0D08, d); chk("R3 unmapped address", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_direct; t_port; t_nested; t_unimpl; t_bytes; t_hold; t_reloc;
    do_reset;
    t_reset;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nrun++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule